// File: doc/BRIEF.md
# Clock Source Select Control Register

This block is a byte-wide control and status register that software writes to pick the source of the system clock. There are three possible sources: the primary oscillator, the PLL output and a low-frequency secondary oscillator. Three fixed inputs decide which register bits software may change and which ones hardware holds at a fixed value. They are the configured oscillator mode, a fuse that permits switching to the secondary source, and the enable bit of the secondary oscillator, which comes from a timer control register. A live PLL lock indication also takes part.

A write sets the stored bits, but only the bits that the present conditions allow. A read always returns the effective value, after forcing. A 2-bit select code drives an external glitch-free clock multiplexer. The code is derived combinationally from the effective bits. When a condition goes away, the effective bit drops at once and the stored bit is cleared on the next clock.

Top module: `clksel_ctrl`

## Requirements
- R1: Read-back bits 7..4 are always 0, and bit 3 always equals the live `pll_locked` input. Writes to these bits have no effect.
- R2: After reset, bit 0 (secondary select), bit 1 (PLL select) and the stored PLL enable are 0, and `src_sel` is 2'b00. Bit 0 is cleared by every reset, even when it is allowed to be set.
- R3: The effective PLL enable is read on bit 2 and depends on the oscillator mode. In hardware-PLL modes (`osc_mode` 3'b100 and 3'b101) it reads 1. In software-PLL modes (3'b110 and 3'b111) it takes the written value of data bit 2. In non-PLL modes (3'b000 to 3'b011) it reads 0 and writes to it are ignored.
- R4: Bit 1 (PLL select) can be set by writing data bit 1 only when all three of these hold: the mode is a software-PLL mode, the PLL enable is 1 after that same write, and `pll_locked` is 1. In every other case a write to bit 1 leaves it 0.
- R5: In the hardware-PLL modes, bit 1 always reads 0 and `src_sel` is never 2'b01.
- R6: Bit 0 (secondary select) can be set by writing data bit 0 only while `sec_sw_fuse_n` is 0 and `sec_osc_en` is 1. Otherwise a write to bit 0 leaves it 0.
- R7: If `pll_locked` falls or the PLL enable is removed, bit 1 and a PLL selection drop in the same cycle. The stored bit is cleared at the next clock, so it stays 0 when lock returns.
- R8: If `sec_osc_en` falls or the fuse is set to 1, bit 0 and a secondary selection drop in the same cycle. The stored bit is cleared at the next clock, so it stays 0 when the condition returns.
- R9: When bit 0 and bit 1 both read 1, `src_sel` selects the secondary source.
- R10: The `src_sel` encoding is 2'b00 for primary, 2'b01 for PLL and 2'b10 for secondary. The value 2'b11 never appears.
- R11: While there is no write and the conditions do not change, the read-back value and `src_sel` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| osc_mode | input | 3 | Configured oscillator mode code |
| sec_sw_fuse_n | input | 1 | Secondary switch fuse; 0 permits switching to the secondary source |
| sec_osc_en | input | 1 | Secondary oscillator enable from the timer control register |
| pll_locked | input | 1 | PLL lock status |
| rd_data | output | 8 | Effective register value for reads |
| src_sel | output | 2 | Clock source select code |

## Verification
Some rules are checked by assertions on every cycle. The select code must never take the unused value. A PLL selection must be backed by lock, by the enable and by bit 1. A secondary selection must be backed by the fuse and the oscillator enable. The hardware-PLL modes must force their values. A lost lock or a lost secondary enable with no write in progress must leave the bit clear one cycle later. Other behaviour only the bench scenarios can show: which values a write actually stores across every mode, fuse, enable, lock and data combination, that bit 0 is cleared by reset, that cleared bits stay clear when their condition returns, and that values hold while idle.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

  localparam int unsigned REG_W  = 8;
  localparam int unsigned MODE_W = 3;
  localparam int unsigned SEL_W  = 2;

  localparam int unsigned BIT_SEC  = 0;
  localparam int unsigned BIT_PSEL = 1;
  localparam int unsigned BIT_PEN  = 2;
  localparam int unsigned BIT_LOCK = 3;

  typedef enum logic [SEL_W-1:0] {
    SRC_PRI = 2'b00,
    SRC_PLL = 2'b01,
    SRC_SEC = 2'b10
  } src_e;

  typedef struct packed {
    logic hw_pll;
    logic sw_pll;
  } mode_cls_t;

endpackage

// File: rtl/clksel_rst_sync.sv
module clksel_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/clksel_mode_dec.sv
module clksel_mode_dec
  import clksel_pkg::*;
(
  input  logic [MODE_W-1:0] osc_mode,
  output mode_cls_t         cls
);

  always_comb begin
    cls.hw_pll = osc_mode[MODE_W-1] & ~osc_mode[MODE_W-2];
    cls.sw_pll = osc_mode[MODE_W-1] &  osc_mode[MODE_W-2];
  end

endmodule

// File: rtl/clksel_bits.sv
module clksel_bits
  import clksel_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic      wd_pen,
  input  logic      wd_psel,
  input  logic      wd_sec,
  input  mode_cls_t cls,
  input  logic      sec_sw_fuse_n,
  input  logic      sec_osc_en,
  input  logic      pll_locked,
  output logic      pen_eff,
  output logic      psel_eff,
  output logic      sec_eff
);

  logic pen_q, psel_q, sec_q;
  logic pen_nxt, psel_nxt, sec_nxt;
  logic psel_ok_now, psel_ok_nxt, sec_ok;
  logic reg_ce;

  always_comb begin
    sec_ok      = ~sec_sw_fuse_n & sec_osc_en;
    pen_nxt     = cls.sw_pll ? (wr_en ? wd_pen : pen_q) : 1'b0;
    psel_ok_nxt = cls.sw_pll & pen_nxt & pll_locked;
    psel_nxt    = psel_ok_nxt ? (wr_en ? wd_psel : psel_q) : 1'b0;
    sec_nxt     = sec_ok ? (wr_en ? wd_sec : sec_q) : 1'b0;
    reg_ce      = wr_en | (pen_q ^ pen_nxt) | (psel_q ^ psel_nxt)
                | (sec_q ^ sec_nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pen_q  <= 1'b0;
      psel_q <= 1'b0;
      sec_q  <= 1'b0;
    end else if (reg_ce) begin
      pen_q  <= pen_nxt;
      psel_q <= psel_nxt;
      sec_q  <= sec_nxt;
    end
  end

  always_comb begin
    pen_eff     = cls.hw_pll | (cls.sw_pll & pen_q);
    psel_ok_now = cls.sw_pll & pen_eff & pll_locked;
    psel_eff    = psel_q & psel_ok_now;
    sec_eff     = sec_q & sec_ok;
  end

  p_sec_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_ok && !wr_en) |=> !sec_q);

  p_psel_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pll_locked && !wr_en) |=> !psel_q);

endmodule

// File: rtl/clksel_src_enc.sv
module clksel_src_enc
  import clksel_pkg::*;
(
  input  logic psel_eff,
  input  logic sec_eff,
  output src_e src
);

  always_comb begin
    if (sec_eff)       src = SRC_SEC;
    else if (psel_eff) src = SRC_PLL;
    else               src = SRC_PRI;
  end

endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
  import clksel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [MODE_W-1:0] osc_mode,
  input  logic              sec_sw_fuse_n,
  input  logic              sec_osc_en,
  input  logic              pll_locked,
  output logic [REG_W-1:0]  rd_data,
  output logic [SEL_W-1:0]  src_sel
);

  logic      rst_n_s;
  mode_cls_t cls;
  logic      pen_eff, psel_eff, sec_eff;
  src_e      src;

  clksel_rst_sync #(.STAGES(2)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  clksel_mode_dec i_dec (.osc_mode(osc_mode), .cls(cls));

  clksel_bits i_bits (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en),
    .wd_pen(wr_data[BIT_PEN]), .wd_psel(wr_data[BIT_PSEL]),
    .wd_sec(wr_data[BIT_SEC]), .cls(cls),
    .sec_sw_fuse_n(sec_sw_fuse_n), .sec_osc_en(sec_osc_en),
    .pll_locked(pll_locked), .pen_eff(pen_eff),
    .psel_eff(psel_eff), .sec_eff(sec_eff)
  );

  clksel_src_enc i_enc (.psel_eff(psel_eff), .sec_eff(sec_eff), .src(src));

  always_comb begin
    rd_data           = '0;
    rd_data[BIT_LOCK] = pll_locked;
    rd_data[BIT_PEN]  = pen_eff;
    rd_data[BIT_PSEL] = psel_eff;
    rd_data[BIT_SEC]  = sec_eff;
    src_sel           = src;
  end

  p_src_legal_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    src_sel != 2'b11);

  p_pll_needs_lock_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (src_sel == SRC_PLL) |-> (pll_locked && rd_data[BIT_PEN] && rd_data[BIT_PSEL]));

  p_sec_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (src_sel == SRC_SEC) |-> (sec_osc_en && !sec_sw_fuse_n && rd_data[BIT_SEC]));

  p_hw_pll_forced_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (osc_mode[2] && !osc_mode[1]) |-> (rd_data[BIT_PEN] && !rd_data[BIT_PSEL]));

  p_lock_drop_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!pll_locked && !wr_en) |=> (src_sel != SRC_PLL || pll_locked));

endmodule

// File: tb/test_clksel_ctrl.sv
module test_clksel_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [2:0] osc_mode;
  logic       sec_sw_fuse_n, sec_osc_en, pll_locked;
  logic [7:0] rd_data;
  logic [1:0] src_sel;

  int total = 0;
  int bad   = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  clksel_ctrl i_clksel_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .osc_mode(osc_mode), .sec_sw_fuse_n(sec_sw_fuse_n),
    .sec_osc_en(sec_osc_en), .pll_locked(pll_locked),
    .rd_data(rd_data), .src_sel(src_sel)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    osc_mode = 3'b000; sec_sw_fuse_n = 1'b1; sec_osc_en = 1'b0; pll_locked = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 reset rd", rd_data, 8'h00);
    check("R2 reset src", src_sel, 0);

    // Sweep: mode, fuse, enable, lock, written low bits (upper bits also set)
    for (int m = 0; m < 8; m++)
      for (int f = 0; f < 2; f++)
        for (int e = 0; e < 2; e++)
          for (int l = 0; l < 2; l++)
            for (int d = 0; d < 8; d++) begin
              logic hw, sw, pe, s1, s0;
              int exp_src;
              @(negedge clk);
              osc_mode = 3'(m); sec_sw_fuse_n = f[0]; sec_osc_en = e[0];
              pll_locked = l[0];
              wr(8'h00);
              wr(8'hF8 | 8'(d));
              hw = (m == 4) || (m == 5);
              sw = (m == 6) || (m == 7);
              pe = hw ? 1'b1 : (sw ? d[2] : 1'b0);
              s1 = sw & pe & l[0] & d[1];
              s0 = ~f[0] & e[0] & d[0];
              exp_src = s0 ? 2 : (s1 ? 1 : 0);
              check("R1 upper/lock", rd_data[7:3], {4'b0, l[0]});
              check(hw ? "R5 pll enable" : "R3 pll enable", rd_data[2], pe);
              check(hw ? "R5 pll select" : "R4 pll select", rd_data[1], s1);
              check("R6 sec select", rd_data[0], s0);
              check((s0 && s1) ? "R9 priority" : "R10 src code", src_sel, exp_src);
            end

    // R7: lose lock after PLL select
    @(negedge clk);
    osc_mode = 3'b110; sec_sw_fuse_n = 1'b1; sec_osc_en = 1'b0; pll_locked = 1'b1;
    wr(8'h06);
    check("R7 set psel", rd_data[1], 1);
    check("R7 src pll", src_sel, 1);
    pll_locked = 1'b0;
    #1;
    check("R7 immediate drop", rd_data[1], 0);
    check("R7 immediate src", src_sel, 0);
    @(negedge clk);
    pll_locked = 1'b1;
    #1;
    check("R7 stays clear", rd_data[1], 0);
    check("R7 src primary", src_sel, 0);

    // R7: remove PLL enable
    wr(8'h06);
    wr(8'h02);
    check("R7 enable off", rd_data[2:1], 0);
    check("R7 enable off src", src_sel, 0);

    // R8: remove secondary enable
    @(negedge clk);
    sec_sw_fuse_n = 1'b0; sec_osc_en = 1'b1;
    wr(8'h01);
    check("R8 set sec", src_sel, 2);
    sec_osc_en = 1'b0;
    #1;
    check("R8 immediate drop", rd_data[0], 0);
    @(negedge clk);
    sec_osc_en = 1'b1;
    #1;
    check("R8 stays clear", rd_data[0], 0);
    check("R8 src primary", src_sel, 0);

    // R11: hold while idle
    wr(8'h07);
    check("R9 both set", src_sel, 2);
    repeat (5) @(negedge clk);
    check("R11 hold rd", rd_data, 8'h0F);
    check("R11 hold src", src_sel, 2);

    // R2: reset clears secondary select even when allowed
    do_reset();
    check("R2 sec after reset", rd_data[0], 0);
    check("R2 pen after reset", rd_data[2], 0);
    check("R2 src after reset", src_sel, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule